// File: doc/BRIEF.md
# Glitch-Free Clock Source Switchover Sequencer

This block changes which of two clock sources feeds a single output clock without ever letting a shortened pulse through. Each source is represented inside a common fast clock domain by a one-cycle tick strobe, and the gated output clock is produced as a gated clock-enable: `clkEnOut` carries the ticks of the selected source while the output is enabled.

When a request asks for the other source, the sequencer works in a fixed order. It waits for a tick of the source that is still selected and turns the output enable off at that point, so the last pulse goes through whole. It then moves the multiplexer select, and counts a programmable number of ticks of the newly selected source. After that count it turns the enable back on. A `busy` flag covers the whole change. Requests that arrive during a change are dropped. A request for the source that is already selected does nothing.

Top module: `clk_swo_seq`

## Requirements
- R1: On reset `activeSrc` is 0, `outEnable` is 1 and `busy` is 0.
- R2: A request (`swReq`=1 while not busy, `swSel` different from `activeSrc`) sets `busy` at the next edge. `outEnable` then stays 1 until the first edge that samples a tick of the still-active source, and it falls at that edge.
- R3: `activeSrc` takes the requested value exactly one cycle after `outEnable` falls. It never changes while `outEnable` is 1 or in the cycle it falls.
- R4: After the select changes, `outEnable` rises at the edge that samples the N-th tick of the new source. N is `waitCycles` latched at request time, with values below 2 treated as 2. Ticks sampled in the cycle the select changes are not counted.
- R5: `busy` stays 1 from the edge after an accepted request until `outEnable` rises. It falls at that same edge.
- R6: A request while `busy` is 1 has no effect on any output, and it does not change the target or the wait count of the change in progress.
- R7: A request whose `swSel` equals `activeSrc` has no effect. `busy` stays 0 and `outEnable` stays 1.
- R8: `clkEnOut` equals the tick of source `activeSrc` (0 selects `srcTick0`, 1 selects `srcTick1`) while `outEnable` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick0 | input | 1 | Tick strobe of source 0 |
| srcTick1 | input | 1 | Tick strobe of source 1 |
| swReq | input | 1 | Switch request, sampled each cycle |
| swSel | input | 1 | Requested source |
| waitCycles | input | CNT_W | New-source ticks to wait before enabling |
| clkEnOut | output | 1 | Gated output clock-enable |
| outEnable | output | 1 | Output enable state |
| activeSrc | output | 1 | Currently selected source |
| busy | output | 1 | Switch in progress |

## Verification
The bench drives both tick streams irregularly, so the old source's tick may arrive late and the new source's count may stall. A design that dropped the enable without waiting for an old tick would cut off the last pulse. A design that counted ticks in the select-change cycle would enable one tick early. Wait values of 0 and 1 check the floor of 2, and a design without the floor would re-enable almost at once. Requests made during a change and requests for the already-selected source are also issued. A design that accepted them would redirect the change or gate the output for no reason.

// File: rtl/clk_swo_pkg.sv
package clk_swo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATE   = 2'd1,
    ST_SWITCH = 2'd2,
    ST_WAIT   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadTgt;
    logic dropEn;
    logic flipSel;
    logic raiseEn;
  } seqStrobe_t;
endpackage

// File: rtl/clk_swo_ctrl.sv
module clk_swo_ctrl
  import clk_swo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReq,
  input  logic             swSel,
  input  logic [CNT_W-1:0] waitCycles,
  input  logic             activeSrc,
  input  logic             curTick,
  output seqStrobe_t       strobe,
  output logic             busy
);
  localparam logic [CNT_W-1:0] MIN_WAIT = CNT_W'(2);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] tickCnt;
  logic             accept;
  logic             lastTick;

  assign accept   = (state == ST_IDLE) && swReq && (swSel != activeSrc);
  assign lastTick = curTick && (tickCnt == limit - CNT_W'(1));

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        stateNext      = ST_GATE;
        strobe.loadTgt = 1'b1;
      end
      ST_GATE: if (curTick) begin
        stateNext     = ST_SWITCH;
        strobe.dropEn = 1'b1;
      end
      ST_SWITCH: begin
        stateNext      = ST_WAIT;
        strobe.flipSel = 1'b1;
      end
      ST_WAIT: if (lastTick) begin
        stateNext      = ST_IDLE;
        strobe.raiseEn = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      limit   <= MIN_WAIT;
      tickCnt <= '0;
    end else begin
      state <= stateNext;
      if (accept) limit <= (waitCycles < MIN_WAIT) ? MIN_WAIT : waitCycles;
      if (state != ST_WAIT)  tickCnt <= '0;
      else if (curTick)      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/clk_swo_dp.sv
module clk_swo_dp
  import clk_swo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcTick0,
  input  logic       srcTick1,
  input  logic       swSel,
  input  seqStrobe_t strobe,
  output logic       curTick,
  output logic       activeSrc,
  output logic       outEnable,
  output logic       clkEnOut
);
  logic tgtSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtSrc    <= 1'b0;
      activeSrc <= 1'b0;
      outEnable <= 1'b1;
    end else begin
      if (strobe.loadTgt) tgtSrc    <= swSel;
      if (strobe.flipSel) activeSrc <= tgtSrc;
      if (strobe.dropEn)       outEnable <= 1'b0;
      else if (strobe.raiseEn) outEnable <= 1'b1;
    end
  end

  assign curTick  = activeSrc ? srcTick1 : srcTick0;
  assign clkEnOut = outEnable & curTick;
endmodule

// File: rtl/clk_swo_seq.sv
module clk_swo_seq
  import clk_swo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTick0,
  input  logic             srcTick1,
  input  logic             swReq,
  input  logic             swSel,
  input  logic [CNT_W-1:0] waitCycles,
  output logic             clkEnOut,
  output logic             outEnable,
  output logic             activeSrc,
  output logic             busy
);
  seqStrobe_t strobe;
  logic       curTick;

  clk_swo_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .swReq(swReq), .swSel(swSel),
    .waitCycles(waitCycles), .activeSrc(activeSrc), .curTick(curTick),
    .strobe(strobe), .busy(busy)
  );

  clk_swo_dp dp_i (
    .clk(clk), .rstN(rstN), .srcTick0(srcTick0), .srcTick1(srcTick1),
    .swSel(swSel), .strobe(strobe), .curTick(curTick),
    .activeSrc(activeSrc), .outEnable(outEnable), .clkEnOut(clkEnOut)
  );
endmodule

// File: rtl/clk_swo_chk.sv
module clk_swo_chk (
  input logic clk,
  input logic rstN,
  input logic srcTick0,
  input logic srcTick1,
  input logic activeSrc,
  input logic outEnable,
  input logic busy
);
  logic selTick;
  assign selTick = activeSrc ? srcTick1 : srcTick0;

  AST_SEL_ONLY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeSrc) |-> (!outEnable && !$past(outEnable))); // R3
  AST_DROP_ON_OLD_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outEnable) |-> ($past(selTick) && $stable(activeSrc))); // R2
  AST_RAISE_ON_NEW_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> $past(selTick)); // R4
  AST_BUSY_ENDS_ON_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $rose(outEnable)); // R5
  AST_IDLE_IS_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> outEnable); // R7
endmodule

bind clk_swo_seq clk_swo_chk chk_i (
  .clk(clk), .rstN(rstN), .srcTick0(srcTick0), .srcTick1(srcTick1),
  .activeSrc(activeSrc), .outEnable(outEnable), .busy(busy)
);

// File: tb/clk_swo_seq_tb.sv
module clk_swo_seq_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcTick0 = 1'b0, srcTick1 = 1'b0, swReq = 1'b0, swSel = 1'b0;
  logic [CNT_W-1:0] waitCycles = '0;
  logic clkEnOut, outEnable, activeSrc, busy;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  int mSrc = 0, mEn = 1, mBusy = 0, mPhase = 0, mTgt = 0, mLim = 2, mCnt = 0;

  always #2 clk = ~clk;

  clk_swo_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .srcTick0(srcTick0), .srcTick1(srcTick1),
    .swReq(swReq), .swSel(swSel), .waitCycles(waitCycles),
    .clkEnOut(clkEnOut), .outEnable(outEnable), .activeSrc(activeSrc), .busy(busy)
  );

  // Reference: phase 0 idle, 1 waiting for old tick, 2 select move, 3 counting
  always @(posedge clk) begin
    if (!rstN) begin
      mSrc = 0; mEn = 1; mBusy = 0; mPhase = 0; mTgt = 0; mLim = 2; mCnt = 0;
    end else begin
      int t;
      t = (mSrc == 1) ? int'(srcTick1) : int'(srcTick0);
      case (mPhase)
        0: if (swReq && int'(swSel) != mSrc) begin
             mBusy = 1; mTgt = int'(swSel); mPhase = 1;
             mLim = (int'(waitCycles) < 2) ? 2 : int'(waitCycles);
           end
        1: if (t == 1) begin mEn = 0; mPhase = 2; end
        2: begin mSrc = mTgt; mPhase = 3; mCnt = 0; end
        default: if (t == 1) begin
             mCnt++;
             if (mCnt == mLim) begin mEn = 1; mBusy = 0; mPhase = 0; end
           end
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int t;
    t = (mSrc == 1) ? int'(srcTick1) : int'(srcTick0);
    chk("R8 clkEnOut", int'(clkEnOut), mEn & t);
    chk("R2/R4 outEnable", int'(outEnable), mEn);
    chk("R3/R6/R7 activeSrc", int'(activeSrc), mSrc);
    chk("R5/R6 busy", int'(busy), mBusy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 activeSrc", int'(activeSrc), 0);
    chk("R1 outEnable", int'(outEnable), 1);
    chk("R1 busy", int'(busy), 0);

    // R7: same-source request while idle
    swReq = 1'b1; swSel = 1'b0; srcTick0 = 1'b1;
    @(negedge clk);
    chk("R7 busy", int'(busy), 0);
    chk("R7 outEnable", int'(outEnable), 1);
    swReq = 1'b0;

    for (int cyc = 0; cyc < 6000; cyc++) begin
      int mode;
      compareAll();
      mode = (cyc / 1500) % 4;
      case (mode)
        0: begin srcTick0 = (cyc % 3 == 0); srcTick1 = (cyc % 5 == 0); end
        1: begin srcTick0 = 1'b1; srcTick1 = 1'b1; end
        2: begin srcTick0 = ($urandom % 7 == 0); srcTick1 = ($urandom % 2 == 0); end
        default: begin srcTick0 = ($urandom % 2 == 0); srcTick1 = ($urandom % 9 == 0); end
      endcase
      // Requests: some while busy (R6), some to same source (R7), wait 0..6 (R4 floor)
      swReq = ($urandom % 6 == 0);
      swSel = ($urandom % 2 == 1);
      waitCycles = CNT_W'($urandom % 7);
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule